// File: doc/BRIEF.md
# Two-Parcel Instruction Issue Pipeline

This block sits between an instruction buffer read port and the issue logic of a processor whose instructions are one or two 16-bit parcels long. Each parcel from the selected buffer passes through two registers: a next-parcel stage and a current-parcel stage. The current-parcel stage is the one that issues. When an instruction is two parcels long, its second parcel does not enter the next-parcel stage. It is written into a separate low-parcel register, and a blank parcel goes into the next-parcel stage in its place. As a result, the low half is already sitting in its register on the same clock that the upper half reaches the current stage.

A simple opcode-field rule sets the length of each parcel. The rule is parameterised as a mask and a pattern. The upstream logic can hold the pipeline in three ways: with a stall input, with a buffer-switch pulse that blocks issue for a fixed number of clocks, and by failing to present the awaited low parcel. While the pipeline is held, nothing moves and any parcel offered on the input is not taken.

Top module: `parcel_issue_pipe`

## Requirements
- R1: While reset is high, and on the first clock after it is released, the current-parcel output and the low-parcel output are both 0 and the issue strobe is low.
- R2: On an advancing clock, a valid parcel that is not a low half is loaded into the next-parcel stage. On the following advancing clock it moves to the current-parcel output, and the issue strobe is high for exactly that one cycle.
- R3: A parcel is the first half of a two-parcel instruction when (parcel AND LEN_MASK) equals LEN_PATTERN. The default for both is 16'h8000, so bit 15 set means two parcels. A parcel with bit 15 clear is one parcel long, and the parcel after it goes to the next-parcel stage, not to the low register.
- R4: The valid parcel taken right after a two-parcel first half is written to the low-parcel output. In that same cycle the next-parcel stage receives a blank, so the low-parcel output already holds the low half when the first half appears on the current-parcel output with issue high.
- R5: A blank parcel that reaches the current stage shows as 0 on the current-parcel output, and the issue strobe stays low.
- R6: When stall is high, the clock after it shows issue low and unchanged current and low outputs. A parcel presented in a stalled cycle is not taken.
- R7: A buffer-switch pulse blocks advance in its own cycle and in the cycle after it (SWITCH_DELAY = 2). Parcels presented in those two cycles are not taken, and issue stays low as a result.
- R8: While a low half is awaited and no valid parcel is presented, the pipeline does not advance: the first half stays in the next-parcel stage and issue stays low.
- R9: On an advancing clock with no valid parcel and no awaited low half, a blank parcel enters the next-parcel stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | 16 | Parcel from the selected instruction buffer |
| par_valid | input | 1 | par_data holds a parcel this cycle |
| stall | input | 1 | Hold the whole pipeline this cycle |
| buf_switch | input | 1 | Pulse: the instruction stream changed buffers |
| cip_parcel | output | 16 | Current (issuing) parcel, 0 when blank |
| lip_parcel | output | 16 | Low parcel of the current two-parcel instruction |
| issue | output | 1 | A non-blank parcel issued from the current stage this cycle |

## Verification
Two events can fall on the same clock: the low parcel is loaded into its register, and the matching first half is loaded into the current stage. The bench sends a long first half followed immediately by its low half. It judges the pair by checking that, in the cycle issue rises, the current and low outputs hold both halves together. Random traffic also lands stall, buffer-switch pulses and gaps in the input stream on that same clock. A behavioural model checks every cycle to confirm that neither half is dropped or duplicated.

// File: rtl/parcel_issue_pkg.sv
package parcel_issue_pkg;
  localparam int PARCEL_W_DEF = 16;

  // Why the pipeline does or does not move on a given clock
  typedef enum logic [1:0] {
    STEP_GO       = 2'd0,
    STEP_STALL    = 2'd1,
    STEP_SWITCH   = 2'd2,
    STEP_WAIT_LOW = 2'd3
  } step_e;
endpackage

// File: rtl/parcel_len_rule.sv
module parcel_len_rule #(
  parameter int          W       = 16,
  parameter logic [W-1:0] MASK    = W'(1) << (W - 1),
  parameter logic [W-1:0] PATTERN = W'(1) << (W - 1)
) (
  input  logic [W-1:0] parcel,
  output logic         two_parcel
);
  generate
    if (MASK == '0) begin : g_never_long
      logic unused_parcel;
      assign unused_parcel = ^parcel;
      assign two_parcel    = 1'b0;
    end else begin : g_field_match
      assign two_parcel = ((parcel & MASK) == PATTERN);
    end
  endgenerate
endmodule

// File: rtl/switch_delay.sv
module switch_delay #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw,
  output logic frozen
);
  localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (sw)        cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign frozen = sw || (cnt != '0);

  generate
    if (DELAY > 1) begin : g_chk
      // R7: the clock after a switch pulse is still frozen
      a_r7_second_cycle: assert property (@(posedge clk) disable iff (rst)
        sw |=> frozen);
    end
  endgenerate
endmodule

// File: rtl/parcel_slot.sv
module parcel_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else if (load) begin
      out_v <= in_v;
      out_d <= in_v ? in_d : '0;
    end
  end

  // R5: a blank slot always carries a zero parcel
  a_r5_blank_is_zero: assert property (@(posedge clk) disable iff (rst)
    !out_v |-> (out_d == '0));
endmodule

// File: rtl/parcel_issue_pipe.sv
module parcel_issue_pipe
  import parcel_issue_pkg::*;
#(
  parameter int                 PARCEL_W     = PARCEL_W_DEF,
  parameter logic [PARCEL_W-1:0] LEN_MASK    = PARCEL_W'(1) << (PARCEL_W - 1),
  parameter logic [PARCEL_W-1:0] LEN_PATTERN = PARCEL_W'(1) << (PARCEL_W - 1),
  parameter int                 SWITCH_DELAY = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PARCEL_W-1:0] par_data,
  input  logic                par_valid,
  input  logic                stall,
  input  logic                buf_switch,
  output logic [PARCEL_W-1:0] cip_parcel,
  output logic [PARCEL_W-1:0] lip_parcel,
  output logic                issue
);
  step_e               step;
  logic                sw_frozen, in_two, cip_two, advance, take;
  logic                pend_q;
  logic                nip_v, cip_v, lip_v;
  logic [PARCEL_W-1:0] nip_d;
  logic                nip_in_v;

  parcel_len_rule #(.W(PARCEL_W), .MASK(LEN_MASK), .PATTERN(LEN_PATTERN))
    u_len_in  (.parcel(par_data),   .two_parcel(in_two));
  parcel_len_rule #(.W(PARCEL_W), .MASK(LEN_MASK), .PATTERN(LEN_PATTERN))
    u_len_cip (.parcel(cip_parcel), .two_parcel(cip_two));

  switch_delay #(.DELAY(SWITCH_DELAY)) u_switch (
    .clk(clk), .rst(rst), .sw(buf_switch), .frozen(sw_frozen));

  always_comb begin
    if (stall)                    step = STEP_STALL;
    else if (sw_frozen)           step = STEP_SWITCH;
    else if (pend_q && !par_valid) step = STEP_WAIT_LOW;
    else                          step = STEP_GO;
  end

  assign advance  = (step == STEP_GO);
  assign take     = advance && par_valid;
  // a low half never enters the next stage: a blank goes in instead
  assign nip_in_v = take && !pend_q;

  parcel_slot #(.W(PARCEL_W)) u_nip (
    .clk(clk), .rst(rst), .load(advance), .in_v(nip_in_v), .in_d(par_data),
    .out_v(nip_v), .out_d(nip_d));

  parcel_slot #(.W(PARCEL_W)) u_cip (
    .clk(clk), .rst(rst), .load(advance), .in_v(nip_v), .in_d(nip_d),
    .out_v(cip_v), .out_d(cip_parcel));

  parcel_slot #(.W(PARCEL_W)) u_lip (
    .clk(clk), .rst(rst), .load(take && pend_q), .in_v(1'b1), .in_d(par_data),
    .out_v(lip_v), .out_d(lip_parcel));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      issue  <= 1'b0;
    end else begin
      issue <= advance && nip_v;
      if (take) pend_q <= pend_q ? 1'b0 : in_two;
    end
  end

  // R2: issue only with a real parcel in the current stage
  a_r2_issue_real: assert property (@(posedge clk) disable iff (rst)
    issue |-> cip_v);
  // R4: the low half is present when its first half issues
  a_r4_lip_ready: assert property (@(posedge clk) disable iff (rst)
    (issue && cip_two) |-> lip_v);
  // R4: taking a low half leaves a blank in the next stage
  a_r4_blank_after_low: assert property (@(posedge clk) disable iff (rst)
    (take && pend_q) |=> !nip_v);
  // R5: blank in current stage never issues
  a_r5_blank_silent: assert property (@(posedge clk) disable iff (rst)
    !cip_v |-> !issue);
  // R6: stall freezes the visible stages
  a_r6_stall_freezes: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!issue && $stable(cip_parcel) && $stable(lip_parcel)));
  // R7: no issue right after a buffer switch pulse
  a_r7_switch_blocks: assert property (@(posedge clk) disable iff (rst)
    buf_switch |=> !issue);
  // R8: waiting for a low half holds everything
  a_r8_wait_freezes: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !par_valid) |=> (!issue && $stable(cip_parcel)));
endmodule

// File: tb/parcel_issue_pipe_test.sv
module parcel_issue_pipe_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] par_data;
  logic        par_valid, stall, buf_switch;
  logic [15:0] cip_parcel, lip_parcel;
  logic        issue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_nip, m_cip, m_lip;
  logic        m_nipv, m_pend, m_iss;
  int          m_hold;

  always #10 clk = ~clk;

  parcel_issue_pipe uut (
    .clk(clk), .rst(rst), .par_data(par_data), .par_valid(par_valid),
    .stall(stall), .buf_switch(buf_switch), .cip_parcel(cip_parcel),
    .lip_parcel(lip_parcel), .issue(issue));

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge(input logic [15:0] d, input logic v,
                            input logic s, input logic w, input logic r);
    bit frz, go;
    if (r) begin
      m_nip = 0; m_cip = 0; m_lip = 0; m_nipv = 0; m_pend = 0; m_iss = 0; m_hold = 0;
    end else begin
      frz    = w || (m_hold > 0);
      m_hold = w ? 1 : (m_hold > 0 ? m_hold - 1 : 0);
      go     = !s && !frz && !(m_pend && !v);
      m_iss  = go && m_nipv;
      if (go) begin
        m_cip = m_nipv ? m_nip : 16'h0;
        if (v && m_pend) begin
          m_lip = d; m_nip = 0; m_nipv = 0; m_pend = 0;
        end else if (v) begin
          m_nip = d; m_nipv = 1; m_pend = d[15];
        end else begin
          m_nip = 0; m_nipv = 0;
        end
      end
    end
  endtask

  // one clock: drive at negedge, model at the edge, compare at next negedge
  task automatic step(input logic [15:0] d, input logic v,
                      input logic s, input logic w);
    par_data = d; par_valid = v; stall = s; buf_switch = w;
    @(posedge clk);
    model_edge(d, v, s, w, rst);
    @(negedge clk);
    chk("R2", "cip model", cip_parcel, m_cip);
    chk("R4", "lip model", lip_parcel, m_lip);
    chk("R5", "issue model", {15'b0, issue}, {15'b0, m_iss});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst = 1; par_data = 0; par_valid = 0; stall = 0; buf_switch = 0;
    @(negedge clk);
    repeat (3) step(16'hffff, 1, 0, 0);
    rst = 0;
    step(0, 0, 0, 0);
    chk("R1", "cip after reset", cip_parcel, 16'h0);
    chk("R1", "lip after reset", lip_parcel, 16'h0);
    chk("R1", "issue after reset", {15'b0, issue}, 16'h0);

    // R2 single parcel
    step(16'h1234, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R2", "short issued", cip_parcel, 16'h1234);
    chk("R2", "issue high", {15'b0, issue}, 16'h1);
    step(0, 0, 0, 0);
    chk("R9", "blank entered", cip_parcel, 16'h0);
    chk("R5", "blank silent", {15'b0, issue}, 16'h0);

    // R3/R4 long pair: low half and first half land together
    step(16'h8001, 1, 0, 0);
    step(16'h0abc, 1, 0, 0);
    chk("R4", "first half in cip", cip_parcel, 16'h8001);
    chk("R4", "low half in lip", lip_parcel, 16'h0abc);
    chk("R4", "issue with pair", {15'b0, issue}, 16'h1);
    step(0, 0, 0, 0);
    chk("R4", "blank behind pair", cip_parcel, 16'h0);
    chk("R5", "no issue of blank", {15'b0, issue}, 16'h0);

    // R3 bit 15 clear is short
    step(16'h7fff, 1, 0, 0);
    step(16'h0111, 1, 0, 0);
    chk("R3", "short first", cip_parcel, 16'h7fff);
    chk("R3", "lip untouched", lip_parcel, 16'h0abc);
    step(0, 0, 0, 0);
    chk("R3", "follower via nip", cip_parcel, 16'h0111);

    // R6 stall
    step(16'h2222, 1, 0, 0);
    held = cip_parcel;
    step(16'h3333, 1, 1, 0);
    chk("R6", "cip held", cip_parcel, held);
    chk("R6", "no issue stalled", {15'b0, issue}, 16'h0);
    step(0, 0, 0, 0);
    chk("R6", "resume", cip_parcel, 16'h2222);
    step(0, 0, 0, 0);
    chk("R6", "stalled parcel not taken", cip_parcel, 16'h0);

    // R7 buffer switch blocks two cycles
    step(16'h4444, 1, 0, 0);
    step(16'h5555, 1, 0, 1);
    chk("R7", "switch cycle", {15'b0, issue}, 16'h0);
    step(16'h6666, 1, 0, 0);
    chk("R7", "second frozen cycle", {15'b0, issue}, 16'h0);
    step(0, 0, 0, 0);
    chk("R7", "after switch", cip_parcel, 16'h4444);
    step(0, 0, 0, 0);
    chk("R7", "frozen parcels not taken", cip_parcel, 16'h0);

    // R8 awaiting low half
    step(16'h8002, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R8", "wait no issue", {15'b0, issue}, 16'h0);
    step(0, 0, 0, 0);
    chk("R8", "wait cip", cip_parcel, 16'h0);
    step(16'h0def, 1, 0, 0);
    chk("R8", "held first half", cip_parcel, 16'h8002);
    chk("R8", "its low half", lip_parcel, 16'h0def);

    // mixed traffic, including stalls and switches on pair edges
    for (int i = 0; i < 600; i++)
      step(16'($urandom), ($urandom % 4) != 0, ($urandom % 6) == 0,
           ($urandom % 20) == 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule